// File: doc/BRIEF.md
# Leaf Reset Cause Checker

This block watches one leaf reset and confirms that each time the leaf goes into reset there is a legitimate cause. A legitimate cause is its parent reset asserting, or a software reset request that is synchronous to the checker's clock. The parent and the leaf may run on clocks unrelated to the checker. Each of them sets a capture flag asynchronously while it is asserted. Each flag is carried into the checker's clock through a flip-flop synchronizer chain.

A five-state machine matches the two synchronized indications. In IDLE, a leaf indication together with a parent indication or the software request moves to WAIT_RELEASE. A leaf indication alone moves to WAIT_PARENT. A parent indication alone moves to WAIT_LEAF. WAIT_PARENT leaves for WAIT_RELEASE when the parent or the software request appears. WAIT_LEAF leaves for WAIT_RELEASE when the leaf appears. Both wait states move to ERROR once the pairing window runs out. The window is `MaxSyncDelay` cycles spent in the wait state.

WAIT_RELEASE acknowledges the capture flags so that they can clear. A flag clears only once its reset has been released. When both synchronized indications read low, the machine returns to IDLE. ERROR drives the error output high and holds it until the checker's own reset. The parameter `CheckEn` removes the whole checker, and the error output then stays low.

Top module: `rst_pair_checker`

## Requirements
- R1: After the checker reset `rst_ni` is released, with both watched resets released, `err_o` is 0.
- R2: If the parent and the leaf both assert in the same cycle, `err_o` stays 0.
- R3: If the leaf asserts alone while `sw_req_i` is 1 at the time the leaf indication is seen, `err_o` stays 0.
- R4: If the parent asserts up to `MaxSyncDelay` cycles after the leaf, `err_o` stays 0. With default parameters a lag of 2 cycles is accepted.
- R5: If the leaf asserts within the window after the parent asserts, `err_o` stays 0. A 1-cycle lag is used for this case.
- R6: If the leaf asserts and neither the parent nor the software request follows within the window, `err_o` rises to 1. This holds for a parent lag of 3 cycles with default parameters, and for no parent at all.
- R7: If the parent asserts and the leaf does not follow within the window, `err_o` rises to 1.
- R8: Once `err_o` is 1, it stays 1 whatever the watched resets do, and it returns to 0 only through `rst_ni`.
- R9: After a valid pairing, holding both resets asserted for any length of time raises no error. Once both are released the checker re-arms, so a later unexplained leaf reset is flagged.
- R10: With `CheckEn` = 0, `err_o` is constantly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Checker's local clock |
| rst_ni | input | 1 | Checker's own reset, active low |
| parent_rst_ni | input | 1 | Watched parent reset, active low, asynchronous |
| leaf_rst_ni | input | 1 | Watched leaf reset, active low, asynchronous |
| sw_req_i | input | 1 | Software reset request, synchronous to `clk_i` |
| err_o | output | 1 | Sticky error: the leaf asserted without cause |

## Verification
The bench builds two copies side by side. One uses the defaults (`CheckEn` = 1, `SyncStages` = 2, `MaxSyncDelay` = 2), and its 2-cycle window makes the edge of the window reachable. At that edge a parent lag of 2 cycles is accepted and a lag of 3 cycles is an error. The second copy is built with `CheckEn` = 0 and receives the same stimulus, so its output must stay low even in the scenarios that drive the enabled copy into ERROR.

// File: rtl/rst_pair_pkg.sv
package rst_pair_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_WAIT_PARENT  = 3'd1,
        ST_WAIT_LEAF    = 3'd2,
        ST_WAIT_RELEASE = 3'd3,
        ST_ERROR        = 3'd4
    } chk_state_e;

endpackage

// File: rtl/rst_pair_flag.sv
module rst_pair_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_rst_ni,
    input  logic ack_i,
    output logic flag_o
);

    always_ff @(posedge clk_i or negedge src_rst_ni) begin
        if (!src_rst_ni) begin
            flag_o <= 1'b1;
        end else if (!rst_ni || ack_i) begin
            flag_o <= 1'b0;
        end
    end

    // R9: while the watched reset is low the capture flag cannot be cleared
    a_r9_flag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !src_rst_ni |-> flag_o);

endmodule

// File: rtl/rst_pair_sync.sv
module rst_pair_sync #(
    parameter int unsigned Stages = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [Stages-1:0] chain_q;

    generate
        if (Stages == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[Stages-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[Stages-1];

endmodule

// File: rtl/rst_pair_fsm.sv
module rst_pair_fsm
    import rst_pair_pkg::*;
#(
    parameter int unsigned MaxSyncDelay = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic parent_seen_i,
    input  logic leaf_seen_i,
    input  logic sw_req_i,
    output logic ack_o,
    output logic err_o
);

    localparam int unsigned TimerW   = (MaxSyncDelay < 2) ? 1 : $clog2(MaxSyncDelay);
    localparam logic [TimerW-1:0] TimerLast = TimerW'(MaxSyncDelay - 1);

    chk_state_e        state_q, state_d;
    logic [TimerW-1:0] timer_q, timer_d;
    logic              waiting;
    logic              expired;

    assign waiting = (state_q == ST_WAIT_PARENT) || (state_q == ST_WAIT_LEAF);
    assign expired = (timer_q == TimerLast);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (leaf_seen_i && (parent_seen_i || sw_req_i)) state_d = ST_WAIT_RELEASE;
                else if (leaf_seen_i)                           state_d = ST_WAIT_PARENT;
                else if (parent_seen_i)                         state_d = ST_WAIT_LEAF;
            end
            ST_WAIT_PARENT: begin
                if (parent_seen_i || sw_req_i) state_d = ST_WAIT_RELEASE;
                else if (expired)              state_d = ST_ERROR;
            end
            ST_WAIT_LEAF: begin
                if (leaf_seen_i)  state_d = ST_WAIT_RELEASE;
                else if (expired) state_d = ST_ERROR;
            end
            ST_WAIT_RELEASE: begin
                if (!leaf_seen_i && !parent_seen_i) state_d = ST_IDLE;
            end
            ST_ERROR: state_d = ST_ERROR;
            default:  state_d = ST_ERROR;
        endcase
    end

    assign timer_d = (waiting && (state_d == state_q)) ? timer_q + 1'b1 : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    always_comb begin
        ack_o = 1'b0;
        err_o = 1'b0;
        unique case (state_q)
            ST_WAIT_RELEASE: ack_o = 1'b1;
            ST_ERROR:        err_o = 1'b1;
            default: ;
        endcase
    end

    // R8: once raised, the error never drops without the checker reset
    a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // R6: the window counter never runs past its limit while waiting
    a_r6_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        waiting |-> (timer_q <= TimerLast));

    // R2: coincident indications from idle go straight to the release wait
    a_r2_pair_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && leaf_seen_i && parent_seen_i) |=> ack_o);

    // R9: waiting for release never produces an error
    a_r9_release_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !err_o);

endmodule

// File: rtl/rst_pair_checker.sv
module rst_pair_checker #(
    parameter bit          CheckEn      = 1'b1,
    parameter int unsigned SyncStages   = 2,
    parameter int unsigned MaxSyncDelay = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic parent_rst_ni,
    input  logic leaf_rst_ni,
    input  logic sw_req_i,
    output logic err_o
);

    generate
        if (CheckEn) begin : g_check
            logic parent_flag, leaf_flag;
            logic parent_seen, leaf_seen;
            logic ack;

            rst_pair_flag u_parent_flag (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .src_rst_ni(parent_rst_ni),
                .ack_i     (ack),
                .flag_o    (parent_flag)
            );

            rst_pair_flag u_leaf_flag (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .src_rst_ni(leaf_rst_ni),
                .ack_i     (ack),
                .flag_o    (leaf_flag)
            );

            rst_pair_sync #(.Stages(SyncStages)) u_parent_sync (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .d_i   (parent_flag),
                .q_o   (parent_seen)
            );

            rst_pair_sync #(.Stages(SyncStages)) u_leaf_sync (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .d_i   (leaf_flag),
                .q_o   (leaf_seen)
            );

            rst_pair_fsm #(.MaxSyncDelay(MaxSyncDelay)) u_fsm (
                .clk_i        (clk_i),
                .rst_ni       (rst_ni),
                .parent_seen_i(parent_seen),
                .leaf_seen_i  (leaf_seen),
                .sw_req_i     (sw_req_i),
                .ack_o        (ack),
                .err_o        (err_o)
            );

            // R7: a parent indication that stays alone past idle cannot release
            a_r7_parent_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (parent_seen && !leaf_seen && !ack && !err_o) |=> !(ack && !leaf_seen && !$past(leaf_seen)) || $past(leaf_seen));
        end else begin : g_off
            assign err_o = 1'b0;
        end
    endgenerate

endmodule

// File: tb/rst_pair_checker_test.sv
module rst_pair_checker_test;

    localparam int SYNC = 2;
    localparam int WIN  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic parent_n = 1'b1;
    logic leaf_n = 1'b1;
    logic sw_req = 1'b0;
    logic err, err_dis;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    rst_pair_checker uut (
        .clk_i(clk), .rst_ni(rst_n), .parent_rst_ni(parent_n),
        .leaf_rst_ni(leaf_n), .sw_req_i(sw_req), .err_o(err)
    );

    rst_pair_checker #(.CheckEn(1'b0)) uut_dis (
        .clk_i(clk), .rst_ni(rst_n), .parent_rst_ni(parent_n),
        .leaf_rst_ni(leaf_n), .sw_req_i(sw_req), .err_o(err_dis)
    );

    // behavioural reference: capture bits, delay queues, pairing tracker
    bit q_par[$];
    bit q_leaf[$];
    bit cap_par = 1'b0;
    bit cap_leaf = 1'b0;
    int mode = 0;      // 0 idle, 1 need parent, 2 need leaf, 3 draining, 4 fault
    int waited = 0;
    bit m_err = 1'b0;

    initial begin
        for (int i = 0; i < SYNC; i++) begin
            q_par.push_back(1'b0);
            q_leaf.push_back(1'b0);
        end
    end

    always @(posedge clk) begin
        bit eff_p, eff_l, sp, sl, draining;
        int nxt;
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) begin q_par[i] = 1'b0; q_leaf[i] = 1'b0; end
            cap_par  = !parent_n;
            cap_leaf = !leaf_n;
            mode = 0; waited = 0; m_err = 1'b0;
        end else begin
            eff_p = cap_par  | !parent_n;
            eff_l = cap_leaf | !leaf_n;
            sp = q_par[0];
            sl = q_leaf[0];
            draining = (mode == 3);
            void'(q_par.pop_front());  q_par.push_back(eff_p);
            void'(q_leaf.pop_front()); q_leaf.push_back(eff_l);
            cap_par  = !parent_n ? 1'b1 : (draining ? 1'b0 : eff_p);
            cap_leaf = !leaf_n   ? 1'b1 : (draining ? 1'b0 : eff_l);
            nxt = mode;
            case (mode)
                0: if (sl && (sp || sw_req)) nxt = 3; else if (sl) nxt = 1; else if (sp) nxt = 2;
                1: if (sp || sw_req) nxt = 3; else if (waited + 1 >= WIN) nxt = 4;
                2: if (sl) nxt = 3; else if (waited + 1 >= WIN) nxt = 4;
                3: if (!sl && !sp) nxt = 0;
                default: nxt = 4;
            endcase
            waited = ((mode == 1 || mode == 2) && nxt == mode) ? waited + 1 : 0;
            mode  = nxt;
            m_err = (mode == 4);
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (err !== m_err) begin
                n_fail++;
                $display("FAIL model R6/R7/R8 t=%0t err=%b expected %b", $time, err, m_err);
            end
            n_tests++;
            if (err_dis !== 1'b0) begin
                n_fail++;
                $display("FAIL R10 disabled copy err=%b expected 0", err_dis);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_err(input logic exp, input string tag);
        n_tests++;
        if (err !== exp) begin
            n_fail++;
            $display("FAIL %s err=%b expected %b", tag, err, exp);
        end
    endtask

    task automatic release_all();
        parent_n = 1'b1; leaf_n = 1'b1; sw_req = 1'b0;
        tick(8);
    endtask

    task automatic checker_reset();
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(3);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        expect_err(1'b0, "R1 after reset");

        // R2: both together
        parent_n = 1'b0; leaf_n = 1'b0; tick(6);
        expect_err(1'b0, "R2 coincident");
        // R9: hold asserted for a long time
        tick(40);
        expect_err(1'b0, "R9 long hold");
        release_all();
        expect_err(1'b0, "R9 released");

        // R3: leaf explained by software request
        leaf_n = 1'b0; sw_req = 1'b1; tick(6);
        sw_req = 1'b0;
        expect_err(1'b0, "R3 software cause");
        release_all();

        // R5: parent first, leaf one cycle later
        parent_n = 1'b0; tick(1); leaf_n = 1'b0; tick(6);
        expect_err(1'b0, "R5 leaf late");
        release_all();

        // R4: leaf first, parent at the window edge
        leaf_n = 1'b0; tick(2); parent_n = 1'b0; tick(6);
        expect_err(1'b0, "R4 parent late by window");
        release_all();

        // R6 and R9 rearm: parent one cycle past the window
        leaf_n = 1'b0; tick(3); parent_n = 1'b0; tick(6);
        expect_err(1'b1, "R6 parent too late (R9 rearmed)");
        release_all();
        tick(20);
        expect_err(1'b1, "R8 sticky after release");
        checker_reset();
        expect_err(1'b0, "R8 cleared by checker reset");

        // R6: leaf with no cause at all
        leaf_n = 1'b0; tick(10);
        expect_err(1'b1, "R6 leaf alone");
        release_all();
        checker_reset();

        // R7: parent without leaf
        parent_n = 1'b0; tick(10);
        expect_err(1'b1, "R7 parent alone");
        release_all();
        expect_err(1'b1, "R8 sticky");
        checker_reset();
        expect_err(1'b0, "R1 reset again");

        n_tests++;
        if (err_dis !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 final err=%b expected 0", err_dis);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule